// File: doc/BRIEF.md
# Ratiometric Displacement Converter with Channel Latch

This block turns a pair of unsigned amplitude samples taken from a differential position transducer into a signed 16-bit displacement word, one word per channel. In the derived-reference wiring (three or four wires) the ratio is the difference of the two amplitudes over their sum. In the primary-reference wiring (two wires) the difference is divided by a separately supplied reference amplitude. A per-channel 16-bit scale register stretches the result so that full scale can be reached with less than full travel. The quotient is then clamped into two's complement and stored in that channel's data register.

Samples arrive one at a time on a valid/ready handshake tagged with a channel number. A single sequential restoring divider serves all channels, so a sample occupies the block for one division. A host reads results through a registered read port. A global latch freezes every channel's stored result so that a consistent snapshot can be read. Reading a channel releases the latch for that channel only.

The controller has three states. IDLE accepts a sample; it goes to DIVIDE when the denominator and the scale are both non-zero, and straight to COMMIT otherwise. DIVIDE waits for the divider's done pulse and then goes to COMMIT. COMMIT writes the clamped result and returns to IDLE.

Top module: `rdc_ratio_conv`

## Requirements
- R1: After reset every channel reads position 0000h and sum 0000h, every scale register holds FFFFh, no channel is latched, and `smp_ready` is 1.
- R2: With the channel's bit in `wire_mode` at 0 (three/four-wire), the stored word is round-half-up of |A−B|·32768·65535 / ((A+B)·scale), negated when B > A.
- R3: With the channel's bit in `wire_mode` at 1 (two-wire), the same formula applies with the denominator A+B replaced by `ref_amp` sampled with the data.
- R4: A positive magnitude above 32767 is stored as 7FFFh, and a negative magnitude above 32768 is stored as 8000h.
- R5: A zero denominator (A+B = 0, or `ref_amp` = 0 in two-wire mode) or a zero scale stores 0000h.
- R6: A `scale_wr` pulse loads `scale_data` into the scale register of `scale_ch` only. FFFFh gives unity gain, and 8000h makes half travel read full scale.
- R7: A `latch_wr` pulse with `latch_data` bit 1 set freezes the position and sum registers of all channels. A `latch_wr` with `latch_data` = 0 releases them all. Any other `latch_data` value has no effect.
- R8: An `rd_en` pulse returns the position and sum of `rd_ch` on `rd_pos`/`rd_sum` one cycle later and releases the latch of that channel alone. A latch write in the same cycle takes precedence.
- R9: The sum register holds A+B, saturated to FFFFh (0.01 V per LSB), in three/four-wire mode, and holds 0 in two-wire mode.
- R10: `smp_ready` is high only in IDLE. A sample is taken when `smp_valid` and `smp_ready` are both high, and `smp_valid` while `smp_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Converter idle, sample will be taken |
| smp_ch | input | CHW | Channel of the offered sample |
| smp_a | input | SW | Amplitude A |
| smp_b | input | SW | Amplitude B |
| ref_amp | input | SW | Reference amplitude for two-wire channels |
| wire_mode | input | NCH | Per-channel mode, 1 = two-wire, 0 = three/four-wire |
| scale_wr | input | 1 | Scale register write strobe |
| scale_ch | input | CHW | Scale register channel |
| scale_data | input | SCW | Scale value |
| latch_wr | input | 1 | Latch register write strobe |
| latch_data | input | 2 | Latch value, bit 1 freezes all |
| rd_en | input | 1 | Read strobe |
| rd_ch | input | CHW | Channel to read |
| rd_pos | output | OW | Position word read |
| rd_sum | output | SW | A+B magnitude read |

## Verification
Three/four-wire samples are applied with A above, below and equal to B. These separate the sign path from the magnitude path and expose a wrong rounding point. Two-wire samples on another channel show that the reference, and not A+B, is the denominator and that the sum register reads zero. Over-range two-wire samples and single-sided four-wire samples hit both clamp limits. A zero sum, a zero reference and a halved scale tell the zero guard and the gain direction apart. Latch, read-release and busy-time samples are checked through the read port against values written before and after the freeze.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_DIVIDE,
        S_COMMIT
    } rdc_state_t;

    localparam int unsigned FREEZE_BIT = 1;
endpackage

// File: rtl/rdc_divider.sv
module rdc_divider #(
    parameter int DW = 48,
    parameter int VW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CW = $clog2(DW + 1);

    logic [VW-1:0] dvs_q;
    logic [VW-1:0] rem_q;
    logic [DW-1:0] dvd_q;
    logic [DW-1:0] quo_q;
    logic [CW-1:0] cnt_q;
    logic [VW:0]   trial;
    logic          fits;

    always_comb begin
        trial = {rem_q, dvd_q[DW-1]};
        fits  = trial >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs_q <= '0;
            rem_q <= '0;
            dvd_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvs_q <= divisor;
                dvd_q <= dividend;
                rem_q <= '0;
                quo_q <= '0;
                cnt_q <= CW'(DW);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? VW'(trial - {1'b0, dvs_q}) : VW'(trial);
                quo_q <= {quo_q[DW-2:0], fits};
                dvd_q <= dvd_q << 1;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // R2: a finished restoring division leaves a remainder below the divisor
    a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < dvs_q));

    // R10: the controller never restarts a division in flight
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/rdc_sat.sv
module rdc_sat #(
    parameter int QW = 48,
    parameter int OW = 16
) (
    input  logic [QW-1:0] quo,
    input  logic          neg,
    input  logic          zero,
    output logic [OW-1:0] res
);
    localparam logic [QW-1:0] POS_LIM = QW'((64'd1 << (OW - 1)) - 64'd1);
    localparam logic [QW-1:0] NEG_LIM = QW'(64'd1 << (OW - 1));

    logic [OW-1:0] low;

    always_comb begin
        low = quo[OW-1:0];
        if (zero) begin
            res = '0;
        end else if (!neg) begin
            res = (quo > POS_LIM) ? {1'b0, {(OW-1){1'b1}}} : low;
        end else begin
            res = (quo > NEG_LIM) ? {1'b1, {(OW-1){1'b0}}} : (~low + OW'(1));
        end
    end
endmodule

// File: rtl/rdc_chan_regs.sv
module rdc_chan_regs
    import rdc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int OW  = 16,
    parameter int SW  = 16,
    parameter int SCW = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [OW-1:0]  wr_pos,
    input  logic [SW-1:0]  wr_sum,
    input  logic           scale_wr,
    input  logic [CHW-1:0] scale_ch,
    input  logic [SCW-1:0] scale_data,
    input  logic [CHW-1:0] sel_ch,
    output logic [SCW-1:0] sel_scale,
    input  logic           latch_wr,
    input  logic [1:0]     latch_data,
    input  logic           rd_en,
    input  logic [CHW-1:0] rd_ch,
    output logic [OW-1:0]  rd_pos,
    output logic [SW-1:0]  rd_sum
);
    logic [OW-1:0]  pos_q   [NCH];
    logic [SW-1:0]  sum_q   [NCH];
    logic [SCW-1:0] scale_q [NCH];
    logic [NCH-1:0] frozen;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pos_q[i]   <= '0;
                sum_q[i]   <= '0;
                scale_q[i] <= '1;
            end else begin
                if (wr_en && wr_ch == CHW'(i) && !frozen[i]) begin
                    pos_q[i] <= wr_pos;
                    sum_q[i] <= wr_sum;
                end
                if (scale_wr && scale_ch == CHW'(i)) begin
                    scale_q[i] <= scale_data;
                end
            end
        end

        // R7: a frozen channel keeps both stored words
        a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
            frozen[i] |=> ($stable(pos_q[i]) && $stable(sum_q[i])));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen <= '0;
        end else if (latch_wr && latch_data[FREEZE_BIT]) begin
            frozen <= '1;
        end else if (latch_wr && latch_data == 2'b00) begin
            frozen <= '0;
        end else if (rd_en) begin
            frozen[rd_ch] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pos <= '0;
            rd_sum <= '0;
        end else if (rd_en) begin
            rd_pos <= pos_q[rd_ch];
            rd_sum <= sum_q[rd_ch];
        end
    end

    assign sel_scale = scale_q[sel_ch];

    // R8: a read with no latch write releases the channel read
    a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !latch_wr) |=> !frozen[$past(rd_ch)]);
endmodule

// File: rtl/rdc_ratio_conv.sv
module rdc_ratio_conv
    import rdc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 16,
    parameter int SCW = 16,
    parameter int OW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    output logic           smp_ready,
    input  logic [CHW-1:0] smp_ch,
    input  logic [SW-1:0]  smp_a,
    input  logic [SW-1:0]  smp_b,
    input  logic [SW-1:0]  ref_amp,
    input  logic [NCH-1:0] wire_mode,
    input  logic           scale_wr,
    input  logic [CHW-1:0] scale_ch,
    input  logic [SCW-1:0] scale_data,
    input  logic           latch_wr,
    input  logic [1:0]     latch_data,
    input  logic           rd_en,
    input  logic [CHW-1:0] rd_ch,
    output logic [OW-1:0]  rd_pos,
    output logic [SW-1:0]  rd_sum
);
    localparam int FRAC = OW - 1;
    localparam int DENW = SW + 1;
    localparam int VW   = DENW + SCW;
    localparam int DW   = SW + SCW + FRAC + 1;
    localparam logic [SCW-1:0] UNITY = '1;

    rdc_state_t state_q, state_d;

    logic           accept, div_start, div_busy, div_done, commit;
    logic [SW-1:0]  mag_now;
    logic [DENW-1:0] den_now;
    logic [SCW-1:0] scale_now;
    logic [VW-1:0]  dvs_now;
    logic [DW-1:0]  dvd_now;
    logic           zero_now;
    logic [SW-1:0]  sum_now;
    logic [DW-1:0]  quo;
    logic [OW-1:0]  res;

    logic [CHW-1:0] cap_ch;
    logic           cap_neg, cap_zero;
    logic [SW-1:0]  cap_sum;

    // operand formation for the offered sample
    always_comb begin
        mag_now  = (smp_a >= smp_b) ? (smp_a - smp_b) : (smp_b - smp_a);
        den_now  = wire_mode[smp_ch] ? DENW'(ref_amp) : (DENW'(smp_a) + DENW'(smp_b));
        dvs_now  = VW'(den_now) * VW'(scale_now);
        dvd_now  = ((DW'(mag_now) * DW'(UNITY)) << FRAC) + DW'(dvs_now >> 1);
        zero_now = (den_now == '0) || (scale_now == '0);
        if (wire_mode[smp_ch]) begin
            sum_now = '0;
        end else begin
            sum_now = (DENW'(smp_a) + DENW'(smp_b) > DENW'({SW{1'b1}})) ? '1
                    : SW'(DENW'(smp_a) + DENW'(smp_b));
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        smp_ready = 1'b0;
        accept    = 1'b0;
        div_start = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                smp_ready = 1'b1;
                if (smp_valid) begin
                    accept    = 1'b1;
                    div_start = !zero_now;
                    state_d   = zero_now ? S_COMMIT : S_DIVIDE;
                end
            end
            S_DIVIDE: begin
                if (div_done) state_d = S_COMMIT;
            end
            S_COMMIT: begin
                commit  = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ch   <= '0;
            cap_neg  <= 1'b0;
            cap_zero <= 1'b0;
            cap_sum  <= '0;
        end else if (accept) begin
            cap_ch   <= smp_ch;
            cap_neg  <= smp_b > smp_a;
            cap_zero <= zero_now;
            cap_sum  <= sum_now;
        end
    end

    rdc_divider #(.DW(DW), .VW(VW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dvd_now),
        .divisor  (dvs_now),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (quo)
    );

    rdc_sat #(.QW(DW), .OW(OW)) u_sat (
        .quo  (quo),
        .neg  (cap_neg),
        .zero (cap_zero),
        .res  (res)
    );

    rdc_chan_regs #(.NCH(NCH), .OW(OW), .SW(SW), .SCW(SCW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_ch      (cap_ch),
        .wr_pos     (res),
        .wr_sum     (cap_sum),
        .scale_wr   (scale_wr),
        .scale_ch   (scale_ch),
        .scale_data (scale_data),
        .sel_ch     (smp_ch),
        .sel_scale  (scale_now),
        .latch_wr   (latch_wr),
        .latch_data (latch_data),
        .rd_en      (rd_en),
        .rd_ch      (rd_ch),
        .rd_pos     (rd_pos),
        .rd_sum     (rd_sum)
    );

    // R10: an accepted sample drops ready on the next cycle
    a_r10_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    // R5: a guarded sample always commits zero
    a_r5_zero_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT && cap_zero) |-> (res == '0));

    // R4: a non-negative ratio never commits a negative word
    a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT && !cap_neg) |-> !res[OW-1]);

    // R2: the divider is idle whenever the controller is idle
    a_r2_idle_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !div_busy);
endmodule

// File: tb/rdc_ratio_conv_tb.sv
module rdc_ratio_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [1:0]  smp_ch = '0;
    logic [15:0] smp_a = '0, smp_b = '0, ref_amp = '0;
    logic [3:0]  wire_mode = 4'b0010;
    logic        scale_wr = 1'b0;
    logic [1:0]  scale_ch = '0;
    logic [15:0] scale_data = '0;
    logic        latch_wr = 1'b0;
    logic [1:0]  latch_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_ch = '0;
    logic [15:0] rd_pos, rd_sum;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] scl [4] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};

    always #5 clk = ~clk;

    rdc_ratio_conv dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_ch(smp_ch), .smp_a(smp_a), .smp_b(smp_b), .ref_amp(ref_amp),
        .wire_mode(wire_mode), .scale_wr(scale_wr), .scale_ch(scale_ch),
        .scale_data(scale_data), .latch_wr(latch_wr), .latch_data(latch_data),
        .rd_en(rd_en), .rd_ch(rd_ch), .rd_pos(rd_pos), .rd_sum(rd_sum)
    );

    function automatic logic [15:0] model_pos(int a, int b, int two, int r, int s);
        longint den, mag, dvs, dvd, q;
        den = two ? r : a + b;
        if (den == 0 || s == 0) return 16'h0000;
        mag = (a >= b) ? a - b : b - a;
        dvs = den * s;
        dvd = mag * 32768 * 65535 + dvs / 2;
        q = dvd / dvs;
        if (a >= b) return (q > 32767) ? 16'h7FFF : 16'(q);
        return (q > 32768) ? 16'h8000 : 16'(-q);
    endfunction

    function automatic logic [15:0] model_sum(int a, int b, int two);
        if (two) return 16'h0000;
        return (a + b > 65535) ? 16'hFFFF : 16'(a + b);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(int ch, int a, int b, int r);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1; smp_ch = 2'(ch); smp_a = 16'(a); smp_b = 16'(b); ref_amp = 16'(r);
        @(negedge clk);
        smp_valid = 1'b0;
        while (!smp_ready) @(negedge clk);
    endtask

    task automatic read_ch(int ch, output logic [15:0] p, output logic [15:0] s);
        @(negedge clk);
        rd_en = 1'b1; rd_ch = 2'(ch);
        @(negedge clk);
        rd_en = 1'b0;
        p = rd_pos; s = rd_sum;
    endtask

    task automatic set_scale(int ch, int v);
        @(negedge clk);
        scale_wr = 1'b1; scale_ch = 2'(ch); scale_data = 16'(v);
        @(negedge clk);
        scale_wr = 1'b0;
        scl[ch] = 16'(v);
    endtask

    task automatic latch_write(int v);
        @(negedge clk);
        latch_wr = 1'b1; latch_data = 2'(v);
        @(negedge clk);
        latch_wr = 1'b0;
    endtask

    task automatic conv_check(string tag, int ch, int a, int b, int r);
        logic [15:0] p, s;
        int two;
        two = int'(wire_mode[ch]);
        send(ch, a, b, r);
        read_ch(ch, p, s);
        check(tag, p, model_pos(a, b, two, r, int'(scl[ch])));
        if (!two) check({tag, " sum R9"}, s, model_sum(a, b, two));
    endtask

    task automatic t_reset();
        logic [15:0] p, s;
        check("R1 ready", {15'd0, smp_ready}, 16'd1);
        for (int c = 0; c < 4; c++) begin
            read_ch(c, p, s);
            check("R1 pos", p, 16'h0000);
            check("R1 sum", s, 16'h0000);
        end
    endtask

    task automatic t_four_wire();
        conv_check("R2 a>b", 0, 3000, 1000, 0);
        conv_check("R2 a<b", 0, 1000, 3000, 0);
        conv_check("R2 a=b", 0, 2500, 2500, 0);
        conv_check("R2 odd", 0, 12345, 321, 0);
    endtask

    task automatic t_two_wire();
        logic [15:0] p, s;
        conv_check("R3 pos", 1, 6000, 1000, 10000);
        conv_check("R3 neg", 1, 1000, 4000, 7000);
        send(1, 40000, 20000, 50000);
        read_ch(1, p, s);
        check("R9 two-wire sum zero", s, 16'h0000);
    endtask

    task automatic t_saturate();
        conv_check("R4 two-wire pos clamp", 1, 30000, 0, 10000);
        conv_check("R4 two-wire neg clamp", 1, 0, 30000, 10000);
        conv_check("R4 full pos", 0, 500, 0, 0);
        conv_check("R4 full neg", 0, 0, 500, 0);
        conv_check("R9 sum saturate", 0, 60000, 50000, 0);
    endtask

    task automatic t_zero_den();
        conv_check("R5 seed", 1, 5000, 1000, 9000);
        conv_check("R5 ref zero", 1, 5000, 1000, 0);
        conv_check("R5 seed4", 0, 700, 100, 0);
        conv_check("R5 sum zero", 0, 0, 0, 0);
    endtask

    task automatic t_scale();
        set_scale(2, 16'h8000);
        conv_check("R6 half travel full", 2, 750, 250, 0);
        conv_check("R6 gain two", 2, 600, 400, 0);
        conv_check("R6 other channel unity", 3, 600, 400, 0);
        set_scale(2, 16'h0000);
        conv_check("R6 zero scale R5", 2, 600, 400, 0);
        set_scale(2, 16'hFFFF);
    endtask

    task automatic t_latch();
        logic [15:0] p, s;
        conv_check("R7 pre0", 0, 900, 100, 0);
        conv_check("R7 pre3", 3, 100, 900, 0);
        latch_write(2);
        send(0, 100, 900, 0);
        send(3, 900, 100, 0);
        read_ch(0, p, s);
        check("R7 frozen ch0", p, model_pos(900, 100, 0, 0, 65535));
        check("R7 frozen ch0 sum", s, 16'd1000);
        send(0, 100, 900, 0);
        read_ch(0, p, s);
        check("R8 ch0 released", p, model_pos(100, 900, 0, 0, 65535));
        read_ch(3, p, s);
        check("R8 ch3 still frozen", p, model_pos(100, 900, 0, 0, 65535));
        latch_write(2);
        latch_write(1);
        send(3, 800, 200, 0);
        latch_write(0);
        send(3, 700, 300, 0);
        read_ch(3, p, s);
        check("R7 release all", p, model_pos(700, 300, 0, 0, 65535));
        latch_write(1);
        send(3, 300, 700, 0);
        read_ch(3, p, s);
        check("R7 other value ignored", p, model_pos(300, 700, 0, 0, 65535));
    endtask

    task automatic t_handshake();
        logic [15:0] p, s;
        conv_check("R10 seed2", 2, 400, 100, 0);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1; smp_ch = 2'd0; smp_a = 16'd5000; smp_b = 16'd1000;
        @(negedge clk);
        check("R10 busy", {15'd0, smp_ready}, 16'd0);
        smp_ch = 2'd2; smp_a = 16'd100; smp_b = 16'd400;
        @(negedge clk);
        smp_valid = 1'b0;
        while (!smp_ready) @(negedge clk);
        read_ch(2, p, s);
        check("R10 busy sample ignored", p, model_pos(400, 100, 0, 0, 65535));
        read_ch(0, p, s);
        check("R10 accepted sample", p, model_pos(5000, 1000, 0, 0, 65535));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_four_wire();
        t_two_wire();
        t_saturate();
        t_zero_den();
        t_scale();
        t_latch();
        t_handshake();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule